// File: doc/BRIEF.md
# Linked Scatter-Gather Descriptor Walker

This block follows a chain of 16-byte scatter-gather descriptors kept in memory and turns each one into a single transfer request for a separate data mover. A start pulse loads the address of the first descriptor. The walker reads the descriptor one 32-bit word at a time and decodes the buffer address, the length, the flags and the DMA mode. It then raises a transfer request and holds it until the request is acknowledged. After the acknowledge it either moves on to the descriptor named by the next pointer or ends the walk.

A descriptor's length is stored in 8-byte units, so the byte count it reports is eight times the stored value. A flag marks the final descriptor. On that descriptor the next pointer is ignored. The walk ends with an error in any of these cases: a non-final descriptor has a null or misaligned next pointer, the start pointer is null or misaligned, or a buffer would run past the top of the 32-bit address space. An abort input drops everything and returns the walker to idle.

Top module: `sg_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `rd_req`, `xfer_req`, `done` and `err` are all 0.
- R2: A descriptor at base P is read as four little-endian words, at P, P+4, P+8 and P+12, with `rd_addr` always word-aligned. The words are used as follows:
  - Word 0 is the buffer address.
  - Word 1 is the length in 8-byte units, and `xfer_bytes` equals that length times 8.
  - In word 2, bits [7:0] are the flags and bits [11:8] are the DMA mode. Bits [15:12] and [31:16] are ignored.
  - In the flags, bit 5 drives `xfer_out`, bit 4 drives `xfer_ordered` and bit 7 marks the final descriptor.
- R3: On a non-final descriptor, the walker fetches the descriptor at the word-3 next pointer after the acknowledge. On a final descriptor, the acknowledge ends the walk with `done`=1 and `err`=0, whatever its next pointer holds.
- R4: Only one request is outstanding at a time. No memory read happens while `xfer_req` is high. `xfer_addr` and `xfer_bytes` stay stable until `xfer_ack`. The next descriptor is fetched only after the acknowledge.
- R5: The walk ends with `done`=1 and `err`=1 in two cases:
  - The acknowledge of a non-final descriptor finds a next pointer that is zero or has any of bits [2:0] set.
  - A start pointer is zero or has any of bits [2:0] set. In this case no memory read is made.
- R6: If a descriptor's address plus byte count exceeds 2^32, the walk ends with `done`=1 and `err`=1 and no request is issued for that descriptor. Ending exactly at 2^32 is allowed.
- R7: `abort` makes the walker idle on the next cycle, with `busy`, `rd_req`, `xfer_req`, `done` and `err` all 0. Any outstanding request is dropped.
- R8: `start` is ignored while `busy` is 1. The current walk, its request and its chain continue unchanged.
- R9: `done` and `err` hold their values after a walk ends until the next accepted `start` (which clears them) or `abort`. `done` is never 1 while `busy` is 1, and `err` is never 1 without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort | input | 1 | Return to idle at once, dropping any request |
| start | input | 1 | Begin a walk at `start_ptr` (ignored while busy) |
| start_ptr | input | AW | Address of the first descriptor |
| rd_req | output | 1 | Memory word read request, held until `rd_valid` |
| rd_addr | output | AW | Byte address of the word being read |
| rd_valid | input | 1 | Memory returns `rd_data` for the current `rd_addr` |
| rd_data | input | 32 | Little-endian descriptor word |
| xfer_req | output | 1 | Transfer request, held until `xfer_ack` |
| xfer_addr | output | AW | Buffer address of the transfer |
| xfer_bytes | output | LW+3 | Byte count (stored length times 8) |
| xfer_out | output | 1 | 1 = toward the device, 0 = from the device |
| xfer_ordered | output | 1 | Ordering flag of the descriptor |
| xfer_mode | output | 4 | DMA mode of the descriptor |
| xfer_ack | input | 1 | Data mover accepts the request |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | The last walk has ended |
| err | output | 1 | The last walk ended on an error |

## Verification
Some properties are checked by assertions on every cycle:
- a memory read and a transfer request are never active together;
- a pending request keeps its address and byte count until it is acknowledged;
- no issued request runs past the 4 GiB limit;
- reads are word-aligned;
- an abort leaves everything idle on the next cycle;
- the end flags stay consistent with `busy`.

Other behaviours only the bench scenarios can show:
- field decoding from little-endian words, including ignored high bits of the mode byte;
- the order in which a three-descriptor chain is visited;
- a final flag overriding a bad next pointer;
- each error cause ending the walk;
- a start pulse during a walk being ignored.

// File: rtl/sg_walker.sv
module sg_walker #(
  parameter int AW    = 32,
  parameter int LW    = 32,
  parameter int ALIGN = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          start,
  input  logic [AW-1:0] start_ptr,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [31:0]   rd_data,
  output logic          xfer_req,
  output logic [AW-1:0] xfer_addr,
  output logic [LW+2:0] xfer_bytes,
  output logic          xfer_out,
  output logic          xfer_ordered,
  output logic [3:0]    xfer_mode,
  input  logic          xfer_ack,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam int BW = LW + 3;
  localparam int SW = ((AW > BW) ? AW : BW) + 1;
  localparam logic [SW-1:0] TOP = SW'(1) << AW;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_ISSUE} st_t;

  st_t           st;
  logic [1:0]    wi;
  logic [AW-1:0] ptr, b_addr, b_next;
  logic [LW-1:0] b_len;
  logic [7:0]    b_flags;
  logic [3:0]    b_mode;

  wire [SW-1:0] end_sum  = SW'(b_addr) + SW'({b_len, 3'b000});
  wire          crosses  = end_sum > TOP;
  wire          next_bad = (b_next == '0) || (|b_next[ALIGN-1:0]);
  wire          ptr_bad  = (start_ptr == '0) || (|start_ptr[ALIGN-1:0]);

  assign busy         = st != S_IDLE;
  assign rd_req       = st == S_FETCH;
  assign rd_addr      = ptr + AW'({wi, 2'b00});
  assign xfer_req     = st == S_ISSUE;
  assign xfer_addr    = b_addr;
  assign xfer_bytes   = {b_len, 3'b000};
  assign xfer_out     = b_flags[5];
  assign xfer_ordered = b_flags[4];
  assign xfer_mode    = b_mode;

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      st   <= S_IDLE;
      wi   <= '0;
      done <= 1'b0;
      err  <= 1'b0;
      if (!rst_n) begin
        ptr     <= '0;
        b_addr  <= '0;
        b_next  <= '0;
        b_len   <= '0;
        b_flags <= '0;
        b_mode  <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (start) begin
          wi <= '0;
          if (ptr_bad) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            done <= 1'b0;
            err  <= 1'b0;
            ptr  <= start_ptr;
            st   <= S_FETCH;
          end
        end
        S_FETCH: if (rd_valid) begin
          case (wi)
            2'd0: b_addr <= rd_data[AW-1:0];
            2'd1: b_len  <= rd_data[LW-1:0];
            2'd2: begin
              b_flags <= rd_data[7:0];
              b_mode  <= rd_data[11:8];
            end
            default: b_next <= rd_data[AW-1:0];
          endcase
          wi <= wi + 2'd1;
          if (wi == 2'd3) begin
            if (crosses) begin
              st   <= S_IDLE;
              done <= 1'b1;
              err  <= 1'b1;
            end else begin
              st <= S_ISSUE;
            end
          end
        end
        S_ISSUE: if (xfer_ack) begin
          if (b_flags[7]) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else if (next_bad) begin
            st   <= S_IDLE;
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            ptr <= b_next;
            wi  <= '0;
            st  <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sg_walker_chk.sv
module sg_walker_chk #(
  parameter int AW = 32,
  parameter int LW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          abort,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          xfer_req,
  input logic [AW-1:0] xfer_addr,
  input logic [LW+2:0] xfer_bytes,
  input logic          xfer_ack,
  input logic          busy,
  input logic          done,
  input logic          err
);
  localparam int BW = LW + 3;
  localparam int SW = ((AW > BW) ? AW : BW) + 1;
  localparam logic [SW-1:0] TOP = SW'(1) << AW;

  a_r4_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && xfer_req));

  a_r4_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack && !abort) |=>
      (xfer_req && $stable(xfer_addr) && $stable(xfer_bytes)));

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> ((SW'(xfer_addr) + SW'(xfer_bytes)) <= TOP));

  a_r2_word_reads: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[1:0] == 2'b00));

  a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !rd_req && !xfer_req && !done && !err));

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_err_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

bind sg_walker sg_walker_chk #(.AW(AW), .LW(LW)) u_chk (.*);

// File: tb/sg_walker_bench.sv
`timescale 1ns/1ps
module sg_walker_bench;
  logic        clk = 0, rst_n = 0, abort = 0, start = 0;
  logic [31:0] start_ptr = 0;
  logic        rd_req, rd_valid = 0;
  logic [31:0] rd_addr, rd_data = 0;
  logic        xfer_req, xfer_out, xfer_ordered, xfer_ack = 0;
  logic [31:0] xfer_addr;
  logic [34:0] xfer_bytes;
  logic [3:0]  xfer_mode;
  logic        busy, done, err;
  logic [31:0] mem [0:63];
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  sg_walker u_sg_walker (.*);

  always @(posedge clk) begin
    rd_valid <= rd_req && !rd_valid;
    rd_data  <= mem[rd_addr[7:2]];
  end

  localparam logic [31:0] V_ADDR [0:3] = '{32'h1000_0000, 32'hFFFF_FF00, 32'h0000_0008, 32'h8000_0004};
  localparam logic [31:0] V_LEN  [0:3] = '{32'd2, 32'd32, 32'h0000_1000, 32'd0};
  localparam logic [7:0]  V_FLG  [0:3] = '{8'h80, 8'hB0, 8'hA0, 8'h90};
  localparam logic [7:0]  V_MB   [0:3] = '{8'h00, 8'h05, 8'hFC, 8'h03};
  localparam logic [31:0] V_NXT  [0:3] = '{32'h0, 32'h0, 32'hDEAD_BEE0, 32'h0000_0013};

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input int base, input logic [31:0] a, input logic [31:0] l,
                     input logic [7:0] f, input logic [7:0] mb, input logic [31:0] n);
    mem[base/4]     = a;
    mem[base/4 + 1] = l;
    mem[base/4 + 2] = {16'hA5C3, mb, f};
    mem[base/4 + 3] = n;
  endtask

  task automatic go(input logic [31:0] p);
    @(negedge clk); start = 1; start_ptr = p;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_req(output bit got);
    got = 0;
    for (int k = 0; k < 200 && !got; k++) begin
      if (xfer_req) got = 1; else @(negedge clk);
    end
  endtask

  task automatic ack;
    @(negedge clk); xfer_ack = 1;
    @(negedge clk); xfer_ack = 0;
  endtask

  task automatic wait_done(output bit saw_req);
    saw_req = 0;
    for (int k = 0; k < 200 && !done; k++) begin
      if (xfer_req) saw_req = 1;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit got, saw;
    logic [31:0] ch_addr [0:2];
    ch_addr = '{32'h2000_0000, 32'h3000_0100, 32'h4000_0000};
    for (int i = 0; i < 64; i++) mem[i] = 0;
    repeat (4) @(negedge clk);
    chk(!busy && !rd_req && !xfer_req && !done && !err, "R1 reset idle",
        {busy, rd_req, xfer_req, done, err}, 0);
    rst_n = 1;

    for (int i = 0; i < 4; i++) begin
      put(32'h40, V_ADDR[i], V_LEN[i], V_FLG[i], V_MB[i], V_NXT[i]);
      go(32'h40);
      wait_req(got);
      chk(got, "R2 request raised", got, 1);
      chk(xfer_addr == V_ADDR[i], "R2 address", xfer_addr, V_ADDR[i]);
      chk(xfer_bytes == {V_LEN[i], 3'b000}, "R2 byte count", xfer_bytes, {V_LEN[i], 3'b000});
      chk(xfer_out == V_FLG[i][5] && xfer_ordered == V_FLG[i][4], "R2 direction/order",
          {xfer_out, xfer_ordered}, {V_FLG[i][5], V_FLG[i][4]});
      chk(xfer_mode == V_MB[i][3:0], "R2 mode", xfer_mode, V_MB[i][3:0]);
      ack;
      wait_done(saw);
      chk(done && !err && !busy, "R3 final entry ends cleanly", {done, err, busy}, 3'b100);
    end

    put(32'h10, ch_addr[0], 32'd4, 8'h00, 8'h01, 32'h80);
    put(32'h80, ch_addr[1], 32'd1, 8'h20, 8'h02, 32'h30);
    put(32'h30, ch_addr[2], 32'd8, 8'h80, 8'h03, 32'h0);
    go(32'h10);
    chk(!done && busy, "R9 start clears done", {done, busy}, 2'b01);
    for (int k = 0; k < 3; k++) begin
      wait_req(got);
      chk(got && xfer_addr == ch_addr[k], "R3 chain order", xfer_addr, ch_addr[k]);
      repeat (3) @(negedge clk);
      chk(xfer_req && !rd_req && xfer_addr == ch_addr[k], "R4 hold without fetch",
          {xfer_req, rd_req}, 2'b10);
      ack;
    end
    wait_done(saw);
    chk(done && !err, "R3 chain end", {done, err}, 2'b10);
    repeat (5) @(negedge clk);
    chk(done && !err && !busy, "R9 status held", {done, err, busy}, 3'b100);

    go(32'h10);
    wait_req(got);
    @(negedge clk); start = 1; start_ptr = 32'h40;
    @(negedge clk); start = 0;
    chk(xfer_req && xfer_addr == ch_addr[0], "R8 start ignored while busy", xfer_addr, ch_addr[0]);
    ack;
    wait_req(got);
    chk(got && xfer_addr == ch_addr[1], "R8 chain continues", xfer_addr, ch_addr[1]);
    @(negedge clk); abort = 1;
    @(negedge clk); abort = 0;
    chk(!busy && !xfer_req && !rd_req && !done && !err, "R7 abort drops request",
        {busy, xfer_req, rd_req, done, err}, 0);
    repeat (6) @(negedge clk);
    chk(!xfer_req && !rd_req && !done, "R7 stays idle", {xfer_req, rd_req, done}, 0);

    go(32'h10);
    @(negedge clk); abort = 1;
    @(negedge clk); abort = 0;
    chk(!busy && !rd_req, "R7 abort during fetch", {busy, rd_req}, 0);

    put(32'h10, 32'h5000_0000, 32'd1, 8'h00, 8'h00, 32'h0);
    go(32'h10);
    wait_req(got);
    chk(got, "R5 request before null next", got, 1);
    ack;
    wait_done(saw);
    chk(done && err, "R5 null next", {done, err}, 2'b11);

    put(32'h10, 32'h5000_0000, 32'd1, 8'h00, 8'h00, 32'h44);
    go(32'h10);
    wait_req(got);
    ack;
    wait_done(saw);
    chk(done && err, "R5 misaligned next", {done, err}, 2'b11);

    put(32'h10, 32'hFFFF_FFF8, 32'd2, 8'h80, 8'h00, 32'h0);
    go(32'h10);
    wait_done(saw);
    chk(done && err && !saw, "R6 wrap rejected without request", {done, err, saw}, 3'b110);

    @(negedge clk); start = 1; start_ptr = 32'h0;
    @(negedge clk); start = 0;
    chk(done && err && !rd_req && !busy, "R5 null start", {done, err, rd_req, busy}, 4'b1100);
    @(negedge clk); start = 1; start_ptr = 32'h44;
    @(negedge clk); start = 0;
    chk(done && err && !rd_req && !busy, "R5 misaligned start", {done, err, rd_req, busy}, 4'b1100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule